// File: doc/BRIEF.md
# Receive Descriptor Ring DMA

This engine places incoming frames into host memory. Software builds a ring of 32-byte descriptors. Each descriptor has an ownership flag, two buffer sizes, two buffer addresses and an end-of-ring mark. The engine reads the current descriptor over a word-wide memory port. If it owns the descriptor, it streams the frame bytes into buffer 1 and then into buffer 2. It then writes a status word back into the descriptor, which also hands ownership back to software. After that it moves on to the next descriptor, or returns to the list base when the end-of-ring mark is set.

When the engine meets a descriptor it does not own, it suspends and raises a buffer-unavailable flag. While suspended it keeps accepting stream bytes and throws them away. A poll-demand strobe makes it read the same descriptor again. The run input starts the engine from the list base. Dropping run stops the engine at the next frame boundary.

Each frame uses exactly one descriptor. Bytes beyond the descriptor's capacity are discarded and the frame is flagged. The stream carries a valid, a last, an error and a frame-type flag. The engine stalls the stream with `s_ready` only while it is reading a descriptor or writing a word.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, `m_req` is low and `rx_unavail` is low.
- R2: When run rises, the first descriptor read is at `list_base`. A descriptor is used only when bit 31 of its word 0 is 1. Byte k of a frame goes to byte lane k mod 4 of a 32-bit little-endian word. Unused lanes of the final word are written as zero.
- R3: Word 1 gives the buffer 1 size in bits 12:0 and the buffer 2 size in bits 28:16. Each size is rounded down to whole words. Buffer 1 (address in word 2) is filled first, then buffer 2 (address in word 3).
- R4: Status is written to word 0 with these fields:
  - bit 31 = 0
  - bits 29:16 = stored length
  - bits 9 and 8 = 1
  - bit 5 = the frame-type flag seen on the last byte
  - bit 1 = the error flag seen on the last byte
  - bit 15 = OR of bit 1 and bit 12
  - all other bits = 0
- R5: A frame longer than the capacity keeps only the first capacity bytes. It reports length = capacity and sets bits 12 and 15.
- R6: After a descriptor whose word 1 bit 15 is set, the next read is at `list_base`. Otherwise the next read is at the current address + 32.
- R7: When a read descriptor is not owned, the engine suspends:
  - `rx_unavail` goes high.
  - No request is issued.
  - Stream bytes are accepted and discarded with no memory write.
- R8: While suspended, a `poll` pulse re-reads the descriptor. If it is now owned, `rx_unavail` falls and the next frame lands in it. If it is still not owned, the engine stays suspended.
- R9: A frame whose head was discarded while suspended is discarded up to and including its last byte, even after reception resumes.
- R10: Clearing run stops the engine at a frame boundary, and `rx_unavail` falls. Setting run again restarts at `list_base`.
- R11: A memory request keeps its address, write flag and write data stable until `m_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| list_base | input | AW | Address of the first descriptor of the ring |
| run | input | 1 | Engine enable |
| poll | input | 1 | Poll-demand strobe |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of frame |
| s_err | input | 1 | Frame error flag, sampled with last |
| s_ftype | input | 1 | Frame-type flag, sampled with last |
| s_ready | output | 1 | Stream byte accepted |
| m_req | output | 1 | Memory request |
| m_we | output | 1 | Request is a write |
| m_addr | output | AW | Byte address, word aligned |
| m_wdata | output | 32 | Write data |
| m_ack | input | 1 | Request accepted; read data valid in this cycle |
| m_rdata | input | 32 | Read data |
| rx_unavail | output | 1 | Suspended on a descriptor not owned by the engine |

## Verification
The bench builds the engine with a 16-bit address so that the whole descriptor ring and all buffers fit in a small word array. The ring has four descriptors with buffers of 16 or 19 bytes plus 8 bytes. With these sizes, several cases are reached with frames of a few dozen bytes:
- spill into buffer 2;
- rounding of an odd size;
- truncation;
- the end-of-ring wrap onto an already-used descriptor, which then forces suspension.

The memory acknowledges with a periodic gap, so requests are held across wait cycles.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] list_base,
  input  logic          run,
  input  logic          poll,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  input  logic          s_err,
  input  logic          s_ftype,
  output logic          s_ready,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [31:0]   m_wdata,
  input  logic          m_ack,
  input  logic [31:0]   m_rdata,
  output logic          rx_unavail
);
  localparam int SZW  = 13;
  localparam int WW   = SZW - 2;
  localparam int IXW  = WW + 1;
  localparam int LENW = IXW + 2;

  typedef enum logic [3:0] {IDLE, RD0, RD1, RD2, RD3, RECV, WDAT, WSTAT, SUSP} st_t;

  st_t st;
  logic [AW-1:0]   ptr, b1, b2;
  logic [WW-1:0]   w1, w2;
  logic            eor, cerr, ftype, trunc, skip, fin;
  logic [LENW-1:0] len;
  logic [IXW-1:0]  widx;
  logic [31:0]     word;
  logic [1:0]      lane;

  wire [IXW-1:0]  cap_w   = {1'b0, w1} + {1'b0, w2};
  wire            room    = len < {cap_w, 2'b00};
  wire            in_b1   = widx < {1'b0, w1};
  wire [IXW-1:0]  b2_idx  = widx - {1'b0, w1};
  wire [AW-1:0]   waddr   = in_b1 ? b1 + AW'({widx, 2'b00}) : b2 + AW'({b2_idx, 2'b00});
  wire            take    = s_valid && s_ready;
  wire            es      = cerr | trunc;
  wire [31:0]     stat    = {2'b00, len, es, 2'b00, trunc, 2'b00, 2'b11, 2'b00, ftype, 3'b000, cerr, 1'b0};

  assign s_ready    = (st == IDLE) || (st == SUSP) || (st == RECV);
  assign rx_unavail = (st == SUSP);
  assign m_req      = (st == RD0) || (st == RD1) || (st == RD2) || (st == RD3) ||
                      (st == WDAT) || (st == WSTAT);
  assign m_we       = (st == WDAT) || (st == WSTAT);
  assign m_wdata    = (st == WSTAT) ? stat : word;

  always_comb begin
    case (st)
      RD1:     m_addr = ptr + AW'(4);
      RD2:     m_addr = ptr + AW'(8);
      RD3:     m_addr = ptr + AW'(12);
      WDAT:    m_addr = waddr;
      default: m_addr = ptr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      ptr <= '0; b1 <= '0; b2 <= '0; w1 <= '0; w2 <= '0;
      eor <= 1'b0; cerr <= 1'b0; ftype <= 1'b0; trunc <= 1'b0;
      skip <= 1'b0; fin <= 1'b0; len <= '0; widx <= '0;
      word <= '0; lane <= '0;
    end else begin
      case (st)
        IDLE: begin
          if (take) skip <= !s_last;
          if (run) begin
            ptr <= list_base;
            st  <= RD0;
          end
        end
        RD0: if (m_ack) begin
          if (!run)            st <= IDLE;
          else if (m_rdata[31]) st <= RD1;
          else                 st <= SUSP;
        end
        RD1: if (m_ack) begin
          w1  <= m_rdata[12:2];
          w2  <= m_rdata[28:18];
          eor <= m_rdata[15];
          st  <= RD2;
        end
        RD2: if (m_ack) begin
          b1 <= m_rdata[AW-1:0];
          st <= RD3;
        end
        RD3: if (m_ack) begin
          b2 <= m_rdata[AW-1:0];
          st <= RECV;
        end
        RECV: begin
          if (take) begin
            if (skip) begin
              skip <= !s_last;
            end else begin
              if (s_last) begin
                cerr  <= s_err;
                ftype <= s_ftype;
              end
              if (room) begin
                word[lane*8 +: 8] <= s_data;
                lane <= lane + 2'd1;
                len  <= len + 1'b1;
                if (lane == 2'd3 || s_last) begin
                  fin <= s_last;
                  st  <= WDAT;
                end
              end else begin
                trunc <= 1'b1;
                if (s_last) st <= WSTAT;
              end
            end
          end else if (!run && len == '0 && !skip) begin
            st <= IDLE;
          end
        end
        WDAT: if (m_ack) begin
          widx <= widx + 1'b1;
          word <= '0;
          lane <= '0;
          st   <= fin ? WSTAT : RECV;
        end
        WSTAT: if (m_ack) begin
          ptr   <= eor ? list_base : ptr + AW'(32);
          len   <= '0; widx <= '0; trunc <= 1'b0;
          cerr  <= 1'b0; ftype <= 1'b0; fin <= 1'b0;
          st    <= RD0;
        end
        SUSP: begin
          if (take) skip <= !s_last;
          if (!run)      st <= IDLE;
          else if (poll) st <= RD0;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_dma_sva.sv
module rx_ring_dma_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          poll,
  input logic          s_ready,
  input logic          m_req,
  input logic          m_we,
  input logic [AW-1:0] m_addr,
  input logic [31:0]   m_wdata,
  input logic          m_ack,
  input logic          rx_unavail
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

  p_susp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_unavail |-> !m_req);

  p_susp_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_unavail |-> s_ready);

  p_wake_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_unavail) |-> ($past(poll) || !$past(run)));
endmodule

bind rx_ring_dma rx_ring_dma_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .run(run), .poll(poll), .s_ready(s_ready),
  .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
  .m_ack(m_ack), .rx_unavail(rx_unavail)
);

// File: tb/rx_ring_dma_tb_top.sv
`timescale 1ns/1ps
module rx_ring_dma_tb_top;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] list_base = 16'h0100;
  logic run = 1'b0, poll = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0, s_ftype = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, m_req, m_we, m_ack, rx_unavail;
  logic [AW-1:0] m_addr;
  logic [31:0] m_wdata, m_rdata;

  logic [31:0] mem [0:16383];
  logic [1:0] acyc = 2'd0;
  int nchk = 0, nfail = 0;
  bit done = 0;
  string drop_tag = "R7";
  logic [AW-1:0] qa[$];
  logic [31:0]   qd[$];
  string         qt[$];
  int sz1[4] = '{16, 19, 16, 16};
  int sz2[4] = '{8, 8, 8, 8};

  assign m_ack   = m_req && (acyc != 2'd3);
  assign m_rdata = mem[m_addr[AW-1:2]];

  rx_ring_dma #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .list_base(list_base), .run(run), .poll(poll),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_err(s_err),
    .s_ftype(s_ftype), .s_ready(s_ready), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata),
    .rx_unavail(rx_unavail)
  );

  always @(posedge clk) begin
    acyc <= acyc + 2'd1;
    if (rst_n && m_req && m_we && m_ack) begin
      mem[m_addr[AW-1:2]] <= m_wdata;
      nchk++;
      if (qa.size() == 0) begin
        nfail++;
        $display("FAIL %s unexpected write act=%h:%h exp=none", drop_tag, m_addr, m_wdata);
      end else begin
        if (m_addr !== qa[0] || m_wdata !== qd[0]) begin
          nfail++;
          $display("FAIL %s write act=%h:%h exp=%h:%h", qt[0], m_addr, m_wdata, qa[0], qd[0]);
        end
        void'(qa.pop_front());
        void'(qd.pop_front());
        void'(qt.pop_front());
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    nchk++; nfail++;
    $display("FAIL R1 watchdog expired act=%0d exp=%0d", 1, 0);
    finish_up();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int seed, input int j);
    return 8'((seed + j * 7) & 255);
  endfunction

  function automatic int daddr(input int i); return 256 + 32 * i; endfunction
  function automatic int b1a(input int i);   return 'h1000 + 'h100 * i; endfunction
  function automatic int b2a(input int i);   return 'h2000 + 'h100 * i; endfunction

  task automatic setup_desc(input int i);
    int a = daddr(i) / 4;
    mem[a]     = 32'h8000_0000;
    mem[a + 1] = 32'(sz1[i] | (sz2[i] << 16) | ((i == 3) ? (1 << 15) : 0));
    mem[a + 2] = 32'(b1a(i));
    mem[a + 3] = 32'(b2a(i));
    for (int k = 4; k < 8; k++) mem[a + k] = 32'h0;
  endtask

  task automatic own(input int i);
    mem[daddr(i) / 4] = 32'h8000_0000;
  endtask

  task automatic expect_frame(input int n, input int seed, input int d,
                              input bit err, input bit ft, input string tag);
    int cap1 = (sz1[d] / 4) * 4;
    int cap  = cap1 + (sz2[d] / 4) * 4;
    int stored = (n < cap) ? n : cap;
    int tr = (n > cap) ? 1 : 0;
    int st;
    logic [31:0] w;
    for (int k = 0; k * 4 < stored; k++) begin
      w = 32'h0;
      for (int b = 0; b < 4; b++)
        if (k * 4 + b < stored) w[b*8 +: 8] = bval(seed, k * 4 + b);
      qa.push_back(AW'((k * 4 < cap1) ? b1a(d) + 4 * k : b2a(d) + 4 * k - cap1));
      qd.push_back(w);
      qt.push_back(tag);
    end
    st = (stored << 16) | (1 << 9) | (1 << 8) | (int'(ft) << 5) | (int'(err) << 1) |
         (tr << 12) | ((int'(err) | tr) << 15);
    qa.push_back(AW'(daddr(d)));
    qd.push_back(32'(st));
    qt.push_back(tag);
  endtask

  task automatic send(input int n, input int seed, input bit fin, input bit err, input bit ft);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = bval(seed, j);
      s_last  = fin && (j == n - 1);
      s_err   = err;
      s_ftype = ft;
      #1;
      while (!s_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic pulse_poll();
    @(negedge clk);
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16384; i++) mem[i] = 32'h0;
    for (int i = 0; i < 4; i++) setup_desc(i);
    repeat (4) @(negedge clk);
    chk(m_req == 1'b0, "R1", "m_req in reset", 32'(m_req), 0);
    chk(rx_unavail == 1'b0, "R1", "rx_unavail in reset", 32'(rx_unavail), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(m_req == 1'b0, "R1", "m_req after reset", 32'(m_req), 0);
    chk(rx_unavail == 1'b0, "R1", "rx_unavail after reset", 32'(rx_unavail), 0);

    run = 1'b1;
    // R2 R4: partial last word, frame type flag
    expect_frame(10, 8'h11, 0, 1'b0, 1'b1, "R2");
    send(10, 8'h11, 1'b1, 1'b0, 1'b1);
    settle();
    // R3: odd buffer-1 size rounded down, spill into buffer 2, error flag
    expect_frame(20, 8'h40, 1, 1'b1, 1'b0, "R3");
    send(20, 8'h40, 1'b1, 1'b1, 1'b0);
    settle();
    // R5: truncation
    expect_frame(30, 8'h80, 2, 1'b0, 1'b0, "R5");
    send(30, 8'h80, 1'b1, 1'b0, 1'b0);
    settle();
    // R3 exact fill of the end-of-ring descriptor
    expect_frame(24, 8'hC3, 3, 1'b0, 1'b0, "R3");
    send(24, 8'hC3, 1'b1, 1'b0, 1'b0);
    settle();
    chk(qa.size() == 0, "R4", "pending writes after four frames", 32'(qa.size()), 0);
    chk(mem[daddr(0) / 4][31] == 1'b0, "R4", "ownership cleared on d0", mem[daddr(0) / 4], 0);

    // R6 wrap reaches d0, already used -> R7 suspend
    chk(rx_unavail == 1'b1, "R7", "suspended after wrap", 32'(rx_unavail), 1);
    drop_tag = "R7";
    send(12, 8'h05, 1'b1, 1'b0, 1'b0);
    settle();
    chk(rx_unavail == 1'b1, "R7", "still suspended after dropped frame", 32'(rx_unavail), 1);
    chk(mem[b1a(0) / 4] == {bval(8'h11, 3), bval(8'h11, 2), bval(8'h11, 1), bval(8'h11, 0)},
        "R7", "d0 buffer untouched", mem[b1a(0) / 4],
        {bval(8'h11, 3), bval(8'h11, 2), bval(8'h11, 1), bval(8'h11, 0)});

    // R8: poll with descriptor still not owned
    pulse_poll();
    settle();
    chk(rx_unavail == 1'b1, "R8", "poll on unowned stays suspended", 32'(rx_unavail), 1);
    own(0);
    pulse_poll();
    settle();
    chk(rx_unavail == 1'b0, "R8", "poll on owned resumes", 32'(rx_unavail), 0);
    // R6: frame lands in d0 after the end-of-ring wrap
    expect_frame(8, 8'h22, 0, 1'b0, 1'b0, "R6");
    send(8, 8'h22, 1'b1, 1'b0, 1'b0);
    settle();
    chk(qa.size() == 0, "R6", "wrapped frame written", 32'(qa.size()), 0);
    chk(rx_unavail == 1'b1, "R7", "suspended on used d1", 32'(rx_unavail), 1);

    // R9: head dropped while suspended, tail must be dropped after resume
    drop_tag = "R9";
    send(5, 8'h33, 1'b0, 1'b0, 1'b0);
    own(1);
    pulse_poll();
    settle();
    chk(rx_unavail == 1'b0, "R8", "resumed on d1", 32'(rx_unavail), 0);
    send(3, 8'h38, 1'b1, 1'b0, 1'b0);
    settle();
    chk(qa.size() == 0, "R9", "no writes for dropped tail", 32'(qa.size()), 0);
    expect_frame(6, 8'h44, 1, 1'b0, 1'b1, "R9");
    send(6, 8'h44, 1'b1, 1'b0, 1'b1);
    settle();
    chk(qa.size() == 0, "R9", "frame after tail lands in d1", 32'(qa.size()), 0);

    // R10: stop and restart from the list base, with d2 owned as a decoy
    own(2);
    own(3);
    @(negedge clk);
    run = 1'b0;
    settle();
    chk(rx_unavail == 1'b0, "R10", "stopped clears unavail", 32'(rx_unavail), 0);
    chk(m_req == 1'b0, "R10", "no request while stopped", 32'(m_req), 0);
    own(0);
    @(negedge clk);
    run = 1'b1;
    settle();
    expect_frame(4, 8'h55, 0, 1'b0, 1'b0, "R10");
    send(4, 8'h55, 1'b1, 1'b0, 1'b0);
    settle();
    chk(qa.size() == 0, "R10", "restart frame in d0", 32'(qa.size()), 0);
    finish_up();
  end
endmodule